// File: doc/BRIEF.md
# ISA Extension Register Write Legalizer

This block holds the machine-level register that tells the rest of a RISC-V hart which instruction-set extensions are switched on. Software writes to it, but a write is only kept if it describes a legal set. An ordered series of rules decides whether the whole write is dropped. If it is kept, the same series clears individual letter bits that the hart cannot support or that conflict with other letters. The 2-bit base-width field at the top of the register never takes a written value.

Each stored letter bit follows the alphabet: bit n stands for the letter 'A'+n. The positions used are A=0, C=2, D=3, E=4, F=5, I=8, M=12, S=18 and U=20. The `impl_mask` input gives, in the same positions, the extensions this hart actually has. Reset loads that mask, limited to the supported letters, together with the base-width parameter.

A write is a single-cycle strobe. There is no back-pressure: a write offered in a cycle is judged in that cycle and either stored at the next clock edge or dropped. When a stored write changes the value, `changed_pulse` is high for exactly one cycle. Downstream decoded or cached state can use this pulse to invalidate itself.

Top module: `isa_ext_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register loads `MXL_RESET` in bits XLEN-1:XLEN-2, `impl_mask` limited to the supported letters in bits 25:0, and zero in all other bits. `changed_pulse` is 0 after reset. `rd_data` always shows the stored value without a cycle of delay.
- R2: A write while `writable_en` is 0 leaves `rd_data` unchanged. A cycle with `wr_en` at 0 also leaves `rd_data` unchanged.
- R3: A write with neither bit 8 (I) nor bit 4 (E) set is discarded completely.
- R4: A write with bit 4 (E) set is discarded completely, whatever its other bits are.
- R5: An accepted value keeps only the letter bits that are set in `impl_mask`.
- R6: Only letters I, E, M, A, F, D, C, S and U can be stored. Every other letter bit, and every bit from 25 up to XLEN-3, reads as zero.
- R7: If bit 3 (D) survives the masking but bit 5 (F) does not, D is cleared.
- R8: If bit 2 (C) survives and `npc_offset` is not 0, C is cleared.
- R9: Writes never change bits XLEN-1:XLEN-2.
- R10: After an accepted write, `changed_pulse` is 1 in the cycle where the new value first appears, and only if that value differs from the previous one. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| writable_en | input | 1 | Strap that allows software writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Value software is writing |
| impl_mask | input | 26 | Letter mask of the extensions this hart implements |
| npc_offset | input | 2 | Low two bits of the next instruction address |
| rd_data | output | XLEN | Stored register value |
| changed_pulse | output | 1 | One-cycle pulse when the stored value changes |

## Verification
Within one accepted write, the D-needs-F clear and the C-alignment clear can both act. The bench provokes this by writing I, D and C together with F missing and `npc_offset` odd. The only correct result is I alone, because either rule applied without the other leaves a D or C bit standing. The same write also has to raise `changed_pulse`. Back-to-back accepted writes check that one pulse per change is reported with no merging.

// File: rtl/isa_ext_pkg.sv
package isa_ext_pkg;
  localparam int LETTERS = 26;
  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;

  function automatic logic [LETTERS-1:0] supported_letters();
    logic [LETTERS-1:0] m;
    m = '0;
    m[BIT_A] = 1'b1;
    m[BIT_C] = 1'b1;
    m[BIT_D] = 1'b1;
    m[BIT_E] = 1'b1;
    m[BIT_F] = 1'b1;
    m[BIT_I] = 1'b1;
    m[BIT_M] = 1'b1;
    m[BIT_S] = 1'b1;
    m[BIT_U] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/isa_ext_legalize.sv
module isa_ext_legalize
  import isa_ext_pkg::*;
(
  input  logic [LETTERS-1:0] wr_letters,
  input  logic [LETTERS-1:0] impl_mask,
  input  logic [1:0]         npc_offset,
  output logic               accept,
  output logic [LETTERS-1:0] legal_letters
);
  localparam logic [LETTERS-1:0] SUP = supported_letters();

  logic [LETTERS-1:0] keep;
  logic [LETTERS-1:0] masked;
  logic [LETTERS-1:0] dep_fixed;

  for (genvar i = 0; i < LETTERS; i++) begin : g_keep
    assign keep[i] = SUP[i] & impl_mask[i];
  end

  always_comb begin
    // ordered accept rules: base letter present, E never accepted
    accept = 1'b1;
    if (!(wr_letters[BIT_I] || wr_letters[BIT_E])) accept = 1'b0;
    if (wr_letters[BIT_E]) accept = 1'b0;

    masked = wr_letters & keep;

    dep_fixed = masked;
    if (masked[BIT_D] && !masked[BIT_F]) dep_fixed[BIT_D] = 1'b0;

    legal_letters = dep_fixed;
    if (dep_fixed[BIT_C] && (npc_offset != 2'b00)) legal_letters[BIT_C] = 1'b0;
  end
endmodule

// File: rtl/isa_ext_state.sv
module isa_ext_state #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rst_val,
  input  logic            load,
  input  logic [XLEN-1:0] next_val,
  output logic [XLEN-1:0] q,
  output logic            changed_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q             <= rst_val;
      changed_pulse <= 1'b0;
    end else begin
      changed_pulse <= load && (next_val != q);
      if (load) q <= next_val;
    end
  end

  // R10: a pulse always marks a real change of the stored value
  a_r10_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    changed_pulse |-> (q != $past(q)));

  // R10: with no load the value and the pulse stay quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q) && !changed_pulse));
endmodule

// File: rtl/isa_ext_reg.sv
module isa_ext_reg
  import isa_ext_pkg::*;
#(
  parameter int         XLEN      = 32,
  parameter logic [1:0] MXL_RESET = 2'b01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                writable_en,
  input  logic                wr_en,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [LETTERS-1:0]  impl_mask,
  input  logic [1:0]          npc_offset,
  output logic [XLEN-1:0]     rd_data,
  output logic                changed_pulse
);
  localparam logic [LETTERS-1:0] SUP = supported_letters();
  localparam int GAP = XLEN - 2 - LETTERS;

  logic               accept;
  logic [LETTERS-1:0] legal_letters;
  logic [XLEN-1:0]    next_val;
  logic [XLEN-1:0]    rst_val;
  logic               load;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^wr_data[XLEN-1:LETTERS];

  isa_ext_legalize u_legal (
    .wr_letters   (wr_data[LETTERS-1:0]),
    .impl_mask    (impl_mask),
    .npc_offset   (npc_offset),
    .accept       (accept),
    .legal_letters(legal_letters)
  );

  assign load     = wr_en && writable_en && accept;
  assign next_val = {rd_data[XLEN-1:XLEN-2], {GAP{1'b0}}, legal_letters};
  assign rst_val  = {MXL_RESET, {GAP{1'b0}}, impl_mask & SUP};

  isa_ext_state #(.XLEN(XLEN)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_val      (rst_val),
    .load         (load),
    .next_val     (next_val),
    .q            (rd_data),
    .changed_pulse(changed_pulse)
  );

  a_r2_strap_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !writable_en |=> $stable(rd_data));

  a_r3_no_base_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[BIT_I] && !wr_data[BIT_E]) |=> $stable(rd_data));

  a_r4_e_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_E]) |=> $stable(rd_data));

  a_r5_within_impl: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[LETTERS-1:0] & ~impl_mask) == '0);

  a_r6_unsupported_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[LETTERS-1:0] & ~SUP) == '0) && (rd_data[XLEN-3:LETTERS] == '0));

  a_r7_d_needs_f: assert property (@(posedge clk) disable iff (!rst_n)
    changed_pulse |-> !(rd_data[BIT_D] && !rd_data[BIT_F]));

  a_r9_mxl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(rd_data[XLEN-1:XLEN-2]));
endmodule

// File: tb/tb_isa_ext_reg.sv
module tb_isa_ext_reg;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            writable_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic [25:0]     impl_mask;
  logic [1:0]      npc_offset = 2'b00;
  logic [XLEN-1:0] rd_data;
  logic            changed_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [XLEN-1:0] model;

  always #2.5 clk = ~clk;

  isa_ext_reg #(.XLEN(XLEN), .MXL_RESET(2'b01)) dut (
    .clk(clk), .rst_n(rst_n), .writable_en(writable_en), .wr_en(wr_en),
    .wr_data(wr_data), .impl_mask(impl_mask), .npc_offset(npc_offset),
    .rd_data(rd_data), .changed_pulse(changed_pulse)
  );

  function automatic logic [XLEN-1:0] letters(string s);
    logic [XLEN-1:0] m = '0;
    for (int k = 0; k < s.len(); k++) m[s[k] - "A"] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] ref_next(logic [XLEN-1:0] cur, logic we,
      logic [XLEN-1:0] d, logic [1:0] pc, logic strap);
    logic [XLEN-1:0] v;
    if (!we || !strap) return cur;
    if (!d["I"-"A"] && !d["E"-"A"]) return cur;
    if (d["E"-"A"]) return cur;
    v = d & {6'b0, impl_mask} & letters("IEMAFDCSU");
    if (v["D"-"A"] && !v["F"-"A"]) v["D"-"A"] = 1'b0;
    if (v["C"-"A"] && (pc % 4 != 0)) v["C"-"A"] = 1'b0;
    v[XLEN-1:XLEN-2] = cur[XLEN-1:XLEN-2];
    return v;
  endfunction

  task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic we, logic [XLEN-1:0] d, logic [1:0] pc, logic strap, string tag);
    logic [XLEN-1:0] exp;
    wr_en = we; wr_data = d; npc_offset = pc; writable_en = strap;
    exp = ref_next(model, we, d, pc, strap);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(tag, "rd_data", rd_data, exp);
    check("R10", "changed_pulse", {31'b0, changed_pulse}, {31'b0, exp != model});
    model = exp;
  endtask

  initial begin
    impl_mask = letters("IMAFDCUXB")[25:0];
    repeat (4) @(posedge clk);
    @(negedge clk);
    model = {2'b01, 4'b0, impl_mask & letters("IEMAFDCSU")[25:0]};
    check("R1", "reset rd_data", rd_data, model);
    check("R1", "reset pulse", {31'b0, changed_pulse}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", rd_data, model);

    step(1, letters("I"), 2'd0, 0, "R2");
    step(1, letters("M"), 2'd0, 1, "R3");
    step(1, letters("IEM"), 2'd0, 1, "R4");
    step(1, 32'hFFFF_FFFF, 2'd0, 1, "R9");
    step(1, letters("IMS"), 2'd0, 1, "R5");
    step(1, letters("IM"), 2'd0, 1, "R10");
    step(1, letters("ID"), 2'd0, 1, "R7");
    step(1, letters("IFDC"), 2'd2, 1, "R8");
    step(1, letters("IDC"), 2'd1, 1, "R7");
    step(1, letters("ICXB") | 32'h0C00_0000, 2'd0, 1, "R6");
    step(0, letters("IMAFDC"), 2'd0, 1, "R2");
    step(1, letters("IMAFDC"), 2'd0, 1, "R10");
    step(1, letters("IA"), 2'd0, 1, "R10");
    step(1, 32'h8000_0100, 2'd3, 1, "R9");
    step(1, 32'd0, 2'd0, 1, "R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule